// File: doc/BRIEF.md
# Widening Signed Left Shifter

This block shifts a signed integer left by a variable count and returns a result twice as wide as the operand. The operand size is one of four widths: 8, 16, 32 or 64 bits. Because the result is doubled, the shift loses no bits for small counts. The result is always right-aligned on a 128-bit bus and sign-extended above bit 2W-1, where W is the operand width. Four flags come out with the result: zero, negative, overflow and excessive shift.

Operations enter on a valid/ready input and leave on a valid-only output, with one result per accepted operation. Narrow operations (8 and 16 bits) take one cycle. Wide operations (32 and 64 bits) take two cycles: a coarse byte-granular shift in the first cycle, then the final bit shift and the flags in the second. A narrow operation that follows a wide one on the next cycle would reach the output on the same edge. The block prevents this by holding off that narrow operation for one cycle. Wide operations are never held off.

Top module: `wsh_top`

## Requirements
- R1: The width code selects the operand width: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. For a count s below 2W, `out_result` holds bits [2W-1:0] of the sign-extended operand times 2^s. Bits 127 down to 2W copy bit 2W-1.
- R2: Operand bits at and above W have no effect on any output.
- R3: A count of 2W or more gives an all-zero result with `out_excess` set. For a count below 2W, `out_excess` is clear.
- R4: `out_overflow` is set when the exact product operand·2^s cannot be held as a 2W-bit signed value. This includes any non-zero operand with an excessive count. Otherwise it is clear.
- R5: `out_zero` is set exactly when the 128-bit result is zero.
- R6: `out_negative` equals bit 2W-1 of the result.
- R7: An 8- or 16-bit operation accepted on a clock edge has its result on `out_valid` right after the next edge (latency 1).
- R8: A 32- or 64-bit operation accepted on a clock edge has its result right after the second following edge (latency 2).
- R9: `in_ready` is low only when the request is 8 or 16 bits wide and a 32/64-bit operation was accepted on the previous edge. Results leave in issue order. Exactly one output cycle is produced per accepted operation.
- R10: After reset, `out_valid` is low and `in_ready` is high.
- R11: `out_width` returns the width code of the operation whose result is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation request |
| in_ready | output | 1 | Request accepted on this edge when high with in_valid |
| in_width | input | 2 | Operand width code (0:8, 1:16, 2:32, 3:64 bits) |
| in_opnd | input | 64 | Operand, right-aligned; upper bits ignored |
| in_count | input | 8 | Unsigned left-shift count |
| out_valid | output | 1 | Result present |
| out_result | output | 128 | Shifted value, 2W bits sign-extended to 128 |
| out_width | output | 2 | Width code of the presented result |
| out_zero | output | 1 | Result is zero |
| out_negative | output | 1 | Result sign bit |
| out_overflow | output | 1 | Product did not fit 2W signed bits |
| out_excess | output | 1 | Count was at or above 2W |

## Verification
The bench tests counts of exactly 2W-1 and 2W at every width. An off-by-one in the excess compare would give a shifted value where zero is expected, or zero where a value is expected. It shifts the most negative and most positive operands by the largest fitting count. A wrong overflow test would flag -2^(2W-1) or miss 2^(2W-1). It puts garbage above bit W to catch a sign taken from the wrong bit. It issues narrow operations on the cycle after wide ones. A missing hold-off would show up as a lost or merged result, or as an extra valid cycle.

// File: rtl/wsh_pkg.sv
// Package: shared width codes and the latency-class helper for the widening
// shifter. Assumes four operand widths, each double the previous.
package wsh_pkg;

    typedef enum logic [1:0] {
        WSEL_BYTE   = 2'd0,
        WSEL_HALF   = 2'd1,
        WSEL_WORD   = 2'd2,
        WSEL_DOUBLE = 2'd3
    } wsel_e;

    // True when a width code belongs to the two-cycle class.
    function automatic logic width_is_slow(input logic [1:0] code,
                                           input logic [1:0] first_slow);
        return code >= first_slow;
    endfunction

endpackage

// File: rtl/wsh_prep.sv
// Module: first half of the shift. Sign-extends the selected operand width,
// detects an excessive count, works out overflow from the operand alone and
// applies the coarse (multiple of 2^FINE_W) part of the shift.
// Assumes: purely combinational; CNT_W holds any value up to 2*MAX_W-1.
module wsh_prep #(
    parameter int MAX_W  = 64,
    parameter int LVLS   = 4,
    parameter int CNT_W  = 8,
    parameter int FINE_W = 3,
    localparam int RES_W  = 2 * MAX_W,
    localparam int LSEL_W = $clog2(LVLS),
    localparam int BASE_W = MAX_W >> (LVLS - 1),
    localparam int DBL_W  = $clog2(RES_W) + 1
) (
    input  logic [MAX_W-1:0]  opnd,
    input  logic [LSEL_W-1:0] wsel,
    input  logic [CNT_W-1:0]  cnt,
    output logic [RES_W-1:0]  coarse,
    output logic [FINE_W-1:0] fine,
    output logic              ovf,
    output logic              exc
);

    logic [MAX_W-1:0]        xs_arr [LVLS];
    logic [MAX_W-1:0]        xs;
    logic signed [MAX_W-1:0] tail;
    logic [DBL_W-1:0]        dbl;
    logic [CNT_W-1:0]        cshift;
    logic                    fits;

    // Build one sign-extended copy of the operand per width.
    for (genvar k = 0; k < LVLS; k++) begin : g_lvl
        localparam int WK = BASE_W << k;
        if (WK < MAX_W) begin : g_pad
            assign xs_arr[k] = {{(MAX_W - WK){opnd[WK-1]}}, opnd[WK-1:0]};
        end else begin : g_full
            assign xs_arr[k] = opnd;
        end
    end

    assign xs  = xs_arr[wsel];
    assign dbl = DBL_W'(2 * BASE_W) << wsel;
    assign exc = 32'(cnt) >= 32'(dbl);

    // Overflow: operand must fit in (2W - count) signed bits.
    always_comb begin : p_ovf
        logic [31:0] room;
        logic [31:0] sh;
        room = 32'(dbl) - 32'd1 - 32'(cnt);
        sh   = (room > 32'(MAX_W - 1)) ? 32'(MAX_W - 1) : room;
        tail = $signed(xs) >>> sh;
        fits = (tail == '0) || (tail == '1);
        ovf  = exc ? (xs != '0) : !fits;
    end

    // Coarse shift by the count with its low FINE_W bits cleared.
    assign cshift = {cnt[CNT_W-1:FINE_W], FINE_W'(0)};
    always_comb begin : p_coarse
        logic [RES_W-1:0] ext;
        ext    = {{(RES_W - MAX_W){xs[MAX_W-1]}}, xs};
        coarse = exc ? '0 : (ext << cshift);
    end

    assign fine = cnt[FINE_W-1:0];

endmodule

// File: rtl/wsh_fine.sv
// Module: second half of the shift. Applies the residual bit shift, cuts the
// value to the doubled width of the selected operand, re-extends its sign to
// the full bus and derives the zero and negative flags.
// Assumes: purely combinational; coarse is already zero for excessive counts.
module wsh_fine #(
    parameter int MAX_W  = 64,
    parameter int LVLS   = 4,
    parameter int FINE_W = 3,
    localparam int RES_W  = 2 * MAX_W,
    localparam int LSEL_W = $clog2(LVLS),
    localparam int BASE_W = MAX_W >> (LVLS - 1)
) (
    input  logic [RES_W-1:0]  coarse,
    input  logic [FINE_W-1:0] fine,
    input  logic [LSEL_W-1:0] wsel,
    output logic [RES_W-1:0]  res,
    output logic              zero,
    output logic              neg
);

    logic [RES_W-1:0] wide;
    logic [RES_W-1:0] alig [LVLS];
    logic             sgn  [LVLS];

    // Residual shift, at most 2^FINE_W-1 places.
    assign wide = coarse << fine;

    // One right-aligned, sign-extended view per doubled width.
    for (genvar k = 0; k < LVLS; k++) begin : g_lvl
        localparam int DK = (2 * BASE_W) << k;
        assign sgn[k] = wide[DK-1];
        if (DK < RES_W) begin : g_pad
            assign alig[k] = {{(RES_W - DK){wide[DK-1]}}, wide[DK-1:0]};
        end else begin : g_full
            assign alig[k] = wide;
        end
    end

    assign res  = alig[wsel];
    assign neg  = sgn[wsel];
    assign zero = (res == '0);

endmodule

// File: rtl/wsh_issue.sv
// Module: admission control. Tracks whether a two-cycle operation sits in the
// middle stage and holds off a one-cycle request that would reach the output
// on the same edge. Two-cycle requests are always admitted.
// Assumes: synchronous active-low reset.
module wsh_issue #(
    parameter int LSEL_W = 2,
    parameter logic [LSEL_W-1:0] SLOW_FROM = LSEL_W'(wsh_pkg::WSEL_WORD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [LSEL_W-1:0] in_wsel,
    output logic              in_ready,
    output logic              take_slow,
    output logic              take_fast,
    output logic              mid_busy
);

    logic req_slow;

    assign req_slow  = in_wsel >= SLOW_FROM;
    // Ready unless a one-cycle request would collide with the middle stage.
    assign in_ready  = !mid_busy || req_slow;
    assign take_slow = in_valid && in_ready && req_slow;
    assign take_fast = in_valid && in_ready && !req_slow;

    // Middle stage occupancy follows every admitted two-cycle operation.
    always_ff @(posedge clk) begin
        if (!rst_n) mid_busy <= 1'b0;
        else        mid_busy <= take_slow;
    end

    AST_FAST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_busy && in_valid && !req_slow) |-> !in_ready);          // R9
    AST_SLOW_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && req_slow) |-> in_ready);                        // R9
    AST_BUSY_FROM_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        mid_busy |-> $past(take_slow));                              // R8

endmodule

// File: rtl/wsh_top.sv
// Module: widening signed left shifter. Operand widths 8..64 bits produce
// results of twice the width, sign-extended on a 128-bit bus, with zero,
// negative, overflow and excessive-shift flags. Narrow widths finish in one
// cycle, wide widths in two; admission control keeps results in order.
// Assumes: synchronous active-low reset; the consumer takes every result.
module wsh_top #(
    parameter int MAX_W  = 64,
    parameter int LVLS   = 4,
    parameter int CNT_W  = 8,
    parameter int FINE_W = 3,
    localparam int RES_W  = 2 * MAX_W,
    localparam int LSEL_W = $clog2(LVLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [LSEL_W-1:0] in_width,
    input  logic [MAX_W-1:0]  in_opnd,
    input  logic [CNT_W-1:0]  in_count,
    output logic              out_valid,
    output logic [RES_W-1:0]  out_result,
    output logic [LSEL_W-1:0] out_width,
    output logic              out_zero,
    output logic              out_negative,
    output logic              out_overflow,
    output logic              out_excess
);

    logic              take_slow, take_fast, mid_valid;
    logic [RES_W-1:0]  p_coarse;
    logic [FINE_W-1:0] p_fine;
    logic              p_ovf, p_exc;
    logic [RES_W-1:0]  f_res;
    logic              f_zero, f_neg;
    logic [RES_W-1:0]  mid_coarse;
    logic [FINE_W-1:0] mid_fine;
    logic [LSEL_W-1:0] mid_wsel;
    logic              mid_ovf, mid_exc;
    logic [RES_W-1:0]  s_res;
    logic              s_zero, s_neg;

    wsh_issue #(.LSEL_W(LSEL_W)) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_wsel   (in_width),
        .in_ready  (in_ready),
        .take_slow (take_slow),
        .take_fast (take_fast),
        .mid_busy  (mid_valid)
    );

    wsh_prep #(.MAX_W(MAX_W), .LVLS(LVLS), .CNT_W(CNT_W), .FINE_W(FINE_W)) u_prep (
        .opnd   (in_opnd),
        .wsel   (in_width),
        .cnt    (in_count),
        .coarse (p_coarse),
        .fine   (p_fine),
        .ovf    (p_ovf),
        .exc    (p_exc)
    );

    // Same-cycle finishing path for one-cycle widths.
    wsh_fine #(.MAX_W(MAX_W), .LVLS(LVLS), .FINE_W(FINE_W)) u_fine_fast (
        .coarse (p_coarse),
        .fine   (p_fine),
        .wsel   (in_width),
        .res    (f_res),
        .zero   (f_zero),
        .neg    (f_neg)
    );

    // Middle stage: capture coarse result of an admitted two-cycle operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid_coarse <= '0;
            mid_fine   <= '0;
            mid_wsel   <= '0;
            mid_ovf    <= 1'b0;
            mid_exc    <= 1'b0;
        end else if (take_slow) begin
            mid_coarse <= p_coarse;
            mid_fine   <= p_fine;
            mid_wsel   <= in_width;
            mid_ovf    <= p_ovf;
            mid_exc    <= p_exc;
        end
    end

    // Second-cycle finishing path for two-cycle widths.
    wsh_fine #(.MAX_W(MAX_W), .LVLS(LVLS), .FINE_W(FINE_W)) u_fine_slow (
        .coarse (mid_coarse),
        .fine   (mid_fine),
        .wsel   (mid_wsel),
        .res    (s_res),
        .zero   (s_zero),
        .neg    (s_neg)
    );

    // Output stage: middle-stage result has the edge, else a fresh narrow one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_result   <= '0;
            out_width    <= '0;
            out_zero     <= 1'b0;
            out_negative <= 1'b0;
            out_overflow <= 1'b0;
            out_excess   <= 1'b0;
        end else if (mid_valid) begin
            out_valid    <= 1'b1;
            out_result   <= s_res;
            out_width    <= mid_wsel;
            out_zero     <= s_zero;
            out_negative <= s_neg;
            out_overflow <= mid_ovf;
            out_excess   <= mid_exc;
        end else if (take_fast) begin
            out_valid    <= 1'b1;
            out_result   <= f_res;
            out_width    <= in_width;
            out_zero     <= f_zero;
            out_negative <= f_neg;
            out_overflow <= p_ovf;
            out_excess   <= p_exc;
        end else begin
            out_valid    <= 1'b0;
        end
    end

    AST_FAST_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        take_fast |=> out_valid);                                    // R7
    AST_SLOW_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        take_slow |-> ##2 out_valid);                                // R8
    AST_NO_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mid_valid && take_fast));                                  // R9
    AST_EXCESS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_excess) |-> (out_result == '0));           // R3
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_zero == (out_result == '0)));             // R5
    AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_negative == out_result[RES_W-1]));        // R6
    AST_WIDTH_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        take_fast |=> (out_width == $past(in_width)));               // R11

endmodule

// File: tb/sim_wsh_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference with a queue of expected results, each due in
// a known cycle; outputs and in_ready are compared every cycle.
module sim_wsh_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [1:0]   in_width = '0;
    logic [63:0]  in_opnd = '0;
    logic [7:0]   in_count = '0;
    logic         out_valid;
    logic [127:0] out_result;
    logic [1:0]   out_width;
    logic         out_zero, out_negative, out_overflow, out_excess;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit prev_slow = 1'b0;

    typedef struct {
        int           due;
        logic [127:0] res;
        logic [1:0]   ws;
        bit           z, n, o, e;
        string        tag;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    wsh_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_width(in_width), .in_opnd(in_opnd), .in_count(in_count),
        .out_valid(out_valid), .out_result(out_result), .out_width(out_width),
        .out_zero(out_zero), .out_negative(out_negative),
        .out_overflow(out_overflow), .out_excess(out_excess)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic exp_t model(input logic [1:0] ws, input logic [63:0] x,
                                   input logic [7:0] c, input string tag);
        exp_t r;
        int w = 8 << ws;
        int d = 2 * w;
        logic [255:0] big, p;
        for (int i = 0; i < 256; i++) big[i] = (i < w) ? x[i] : x[w-1];
        r.ws = ws; r.tag = tag; r.due = 0;
        r.e = (int'(c) >= d);
        r.o = 1'b0;
        r.res = '0;
        if (r.e) begin
            r.o = (big != '0);
        end else begin
            p = big << c;
            for (int i = 0; i < 128; i++) r.res[i] = (i < d) ? p[i] : p[d-1];
            for (int i = d - 1; i < 256; i++) if (p[i] != p[d-1]) r.o = 1'b1;
        end
        r.z = (r.res == '0);
        r.n = r.res[d-1];
        return r;
    endfunction

    // Compare outputs presented in this cycle with the model's due entry.
    task automatic check_outputs();
        if (q.size() > 0 && q[0].due == cyc) begin
            exp_t e = q.pop_front();
            chk(out_valid === 1'b1, (e.ws >= 2) ? "R8" : "R7", "result valid", 128'(out_valid), 128'd1);
            chk(out_result === e.res, e.tag, "result value", out_result, e.res);
            chk(out_width === e.ws, "R11", "width echo", 128'(out_width), 128'(e.ws));
            chk(out_excess === e.e, "R3", "excess flag", 128'(out_excess), 128'(e.e));
            chk(out_overflow === e.o, "R4", "overflow flag", 128'(out_overflow), 128'(e.o));
            chk(out_zero === e.z, "R5", "zero flag", 128'(out_zero), 128'(e.z));
            chk(out_negative === e.n, "R6", "negative flag", 128'(out_negative), 128'(e.n));
        end else begin
            chk(out_valid === 1'b0, "R9", "no unexpected result", 128'(out_valid), 128'd0);
        end
    endtask

    // One cycle: check outputs, drive a request, record acceptance.
    task automatic step(input bit v, input logic [1:0] ws, input logic [63:0] x,
                        input logic [7:0] c, input string tag, output bit acc);
        bit slow, rdy_exp;
        @(negedge clk);
        cyc++;
        check_outputs();
        in_valid = v; in_width = ws; in_opnd = x; in_count = c;
        #1;
        slow = (ws >= 2);
        rdy_exp = !prev_slow || slow;
        acc = 1'b0;
        if (v) begin
            chk(in_ready === rdy_exp, "R9", "ready", 128'(in_ready), 128'(rdy_exp));
            acc = v && in_ready;
        end
        if (acc) begin
            exp_t e = model(ws, x, c, tag);
            e.due = cyc + (slow ? 2 : 1);
            q.push_back(e);
        end
        prev_slow = acc && slow;
    endtask

    task automatic issue(input logic [1:0] ws, input logic [63:0] x,
                         input logic [7:0] c, input string tag);
        bit acc = 1'b0;
        int tries = 0;
        while (!acc && tries < 4) begin
            step(1'b1, ws, x, c, tag, acc);
            tries++;
        end
        if (!acc) chk(1'b0, "R9", "request never admitted", 128'd0, 128'd1);
    endtask

    task automatic idle(input int n);
        bit acc;
        for (int i = 0; i < n; i++) step(1'b0, 2'd0, 64'd0, 8'd0, "R1", acc);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid === 1'b0, "R10", "valid in reset", 128'(out_valid), 128'd0);
        rst_n = 1'b1;
        #1;
        chk(in_ready === 1'b1, "R10", "ready after reset", 128'(in_ready), 128'd1);
        idle(1);

        // Byte corners: sign, exact fit, overflow, 2W-1 and 2W counts (R1 R3 R4).
        issue(2'd0, 64'h80, 8'd1, "R1");
        issue(2'd0, 64'h7f, 8'd9, "R4");
        issue(2'd0, 64'h01, 8'd15, "R4");
        issue(2'd0, 64'hff, 8'd15, "R1");
        issue(2'd0, 64'h01, 8'd16, "R3");
        issue(2'd0, 64'h00, 8'd200, "R3");
        issue(2'd0, 64'h00, 8'd0, "R5");
        // Garbage above the operand width must not matter (R2).
        issue(2'd0, 64'hdead_beef_cafe_ff05, 8'd3, "R2");
        issue(2'd1, 64'h1234_5678_9abc_8001, 8'd4, "R2");
        issue(2'd2, 64'hffff_ffff_0000_0010, 8'd2, "R2");
        // Half and word edges.
        issue(2'd1, 64'h8000, 8'd16, "R1");
        issue(2'd1, 64'h4000, 8'd17, "R4");
        issue(2'd1, 64'h0001, 8'd32, "R3");
        issue(2'd2, 64'h8000_0000, 8'd31, "R1");
        issue(2'd2, 64'h0000_0001, 8'd63, "R4");
        issue(2'd2, 64'hffff_ffff, 8'd63, "R1");
        issue(2'd2, 64'h0000_0001, 8'd64, "R3");
        // Double edges at 127 and 128.
        issue(2'd3, 64'hffff_ffff_ffff_ffff, 8'd127, "R1");
        issue(2'd3, 64'h0000_0000_0000_0001, 8'd127, "R4");
        issue(2'd3, 64'h8000_0000_0000_0000, 8'd64, "R1");
        issue(2'd3, 64'h8000_0000_0000_0000, 8'd65, "R4");
        issue(2'd3, 64'h0000_0000_0000_0001, 8'd128, "R3");
        issue(2'd3, 64'h0, 8'd255, "R3");
        // Narrow right after wide: hold-off and ordering (R9).
        issue(2'd2, 64'h1, 8'd5, "R8");
        issue(2'd0, 64'h3, 8'd2, "R9");
        issue(2'd3, 64'h5, 8'd7, "R8");
        issue(2'd3, 64'h6, 8'd8, "R8");
        issue(2'd1, 64'h7, 8'd9, "R9");
        issue(2'd0, 64'h9, 8'd1, "R7");
        issue(2'd2, 64'ha, 8'd3, "R8");
        idle(3);

        // Mixed random traffic with gaps.
        for (int n = 0; n < 600; n++) begin
            logic [1:0] ws = 2'($urandom_range(0, 3));
            logic [63:0] x = {$urandom, $urandom};
            int d = 16 << ws;
            logic [7:0] c = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, d + 1));
            if ($urandom_range(0, 4) == 0) idle(1);
            issue(ws, x, c, "R1");
        end
        idle(4);
        chk(q.size() == 0, "R9", "all results delivered", 128'(q.size()), 128'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R9: actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule